// File: doc/BRIEF.md
# Voice Playout Jitter Buffer

This block sits between a byte-oriented serial receiver and a two-channel audio DAC in a voice link. Compressed voice bytes (A-law, one byte per sample) arrive in bursts of a packet at a time. Playout runs at a steady sample rate of a few kHz. The block stores the bytes in a ring and, on every sample tick, picks one code to play. It expands that code to a 16-bit linear sample, shifts the sample into unsigned DAC range and presents it on both channels with a valid pulse.

The fill level sets the playout policy. With nothing stored, the block plays the silence code. With more than half the capacity stored, it drops the oldest byte and plays the next one, so a link running fast is pulled back in. In every other case it plays exactly one byte per tick. The fill count and three flags (empty, full and a sticky overflow) are brought out.

Top module: `voice_playout_buffer`

## Requirements
- R1: After reset, fill is 0, empty is 1, full is 0, overflow is 0 and out_valid is 0.
- R2: A write offered while fill is below the capacity (255 by default) stores the byte at the tail and raises fill by one. Full reads 1 exactly when fill equals the capacity, and empty reads 1 exactly when fill is 0.
- R3: A write offered while fill equals the capacity is dropped, even if a tick falls in the same cycle. It sets overflow, which then stays at 1 until reset.
- R4: A tick seen with fill 0 plays code 0xD5, which decodes to linear +8 and gives output 0x8007. Fill stays unchanged.
- R5: A tick seen with fill from 1 to half the capacity (127 by default) removes and plays the oldest byte, so fill drops by one.
- R6: A tick seen with fill above half the capacity removes two bytes, discards the older one and plays the second, so fill drops by two.
- R7: A write and a tick in the same cycle both take effect. The playout choice uses the fill from before that cycle, so a write into an empty buffer together with a tick still plays silence and leaves fill at 1.
- R8: The played code is decoded by standard A-law rules. XOR the code with 0x55. Bit 7 set means positive. Bits 6:4 are the segment s and bits 3:0 the mantissa m. The magnitude is 16m+8 when s is 0, and (16m+264)·2^(s-1) otherwise. The output is the signed linear value plus 0x7FFF, modulo 2^16, and it appears on both channels.
- R9: out_valid is high for one cycle, two cycles after the cycle in which tick is high, and never at any other time. The channel outputs hold their value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Incoming byte strobe |
| wr_byte_i | input | 8 | Incoming A-law byte |
| tick_i | input | 1 | Sample tick, one cycle per playout sample |
| ch_a_o | output | 16 | Unsigned sample, channel A |
| ch_b_o | output | 16 | Unsigned sample, channel B |
| out_valid_o | output | 1 | One-cycle pulse marking a new sample |
| fill_o | output | 8 | Bytes currently stored |
| empty_o | output | 1 | Fill is zero |
| full_o | output | 1 | Fill equals capacity |
| overflow_o | output | 1 | Sticky: a write was dropped |

## Verification
The bench goes after the fill thresholds. These are tick at exactly half, one above half, at zero and at full capacity. A design that compared against the wrong threshold would play a byte late or drain two bytes too early, and the scoreboard would see the sample stream slip. Write-plus-tick cycles at empty and at full catch a design that bases the decision on the updated fill: it would play a fresh byte instead of silence, or accept a write into a full ring. Codes covering every segment, both signs and the silence code catch errors in decoding or in the offset, and a check on channel equality catches a channel that was not updated.

// File: rtl/vpjb_pkg.sv
package vpjb_pkg;

  localparam logic [7:0] SILENCE_CODE = 8'hD5;
  localparam logic [15:0] DAC_MID = 16'h7FFF;

  typedef enum logic [1:0] {
    MODE_SILENT  = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_CATCHUP = 2'd2
  } play_mode_e;

  // A-law code to signed linear 16-bit
  function automatic logic signed [15:0] alaw_to_lin(input logic [7:0] code);
    logic [7:0]  a;
    logic [2:0]  seg;
    logic [15:0] mag;
    a   = code ^ 8'h55;
    seg = a[6:4];
    mag = {8'd0, a[3:0], 4'd0};
    if (seg == 3'd0) mag = mag + 16'd8;
    else             mag = (mag + 16'h0108) << (seg - 3'd1);
    alaw_to_lin = a[7] ? $signed(mag) : -$signed(mag);
  endfunction

  // Signed linear to unsigned DAC word
  function automatic logic [15:0] lin_to_dac(input logic signed [15:0] lin);
    lin_to_dac = $unsigned(lin) + DAC_MID;
  endfunction

endpackage

// File: rtl/vpjb_ring.sv
module vpjb_ring #(
  parameter int CAP = 255,
  localparam int PTR_W = $clog2(CAP),
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [7:0]       din_i,
  input  logic [1:0]       pop_cnt_i,
  output logic [7:0]       head_o,
  output logic [7:0]       next_o,
  output logic [CNT_W-1:0] count_o,
  output logic             push_ok_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);

  logic [7:0]       mem [CAP];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, rd_ptr_1, rd_ptr_2;
  logic [CNT_W-1:0] count_q;
  logic             ovf_q;
  logic             push_drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    ptr_inc = (p == PTR_W'(CAP - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_ptr_1  = ptr_inc(rd_ptr_q);
  assign rd_ptr_2  = ptr_inc(rd_ptr_1);
  assign push_ok_o = push_i && (count_q != CAP_C);
  assign push_drop = push_i && (count_q == CAP_C);
  assign head_o    = mem[rd_ptr_q];
  assign next_o    = mem[rd_ptr_1];
  assign count_o   = count_q;
  assign empty_o   = (count_q == '0);
  assign full_o    = (count_q == CAP_C);
  assign ovf_o     = ovf_q;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_ok_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      case (pop_cnt_i)
        2'd1:    rd_ptr_q <= rd_ptr_1;
        2'd2:    rd_ptr_q <= rd_ptr_2;
        default: rd_ptr_q <= rd_ptr_q;
      endcase
      count_q <= count_q + CNT_W'(push_ok_o) - CNT_W'(pop_cnt_i);
      if (push_drop) ovf_q <= 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CAP_C); // R2
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> (ovf_o && count_o <= $past(count_o))); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R3
  AST_POP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {6'd0, pop_cnt_i} <= 8'(count_q)); // R6

endmodule

// File: rtl/vpjb_sel.sv
module vpjb_sel
  import vpjb_pkg::*;
#(
  parameter int CAP = 255,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       head_i,
  input  logic [7:0]       next_i,
  output logic [1:0]       pop_cnt_o,
  output logic [7:0]       code_o,
  output logic             code_vld_o
);

  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(CAP / 2);

  play_mode_e mode;
  logic [7:0] pick;
  logic [7:0] code_q;
  logic       code_vld_q;

  always_comb begin
    if (count_i == '0)        mode = MODE_SILENT;
    else if (count_i > HALF_C) mode = MODE_CATCHUP;
    else                      mode = MODE_NORMAL;
    case (mode)
      MODE_SILENT:  begin pick = SILENCE_CODE; pop_cnt_o = 2'd0; end
      MODE_CATCHUP: begin pick = next_i;       pop_cnt_o = 2'd2; end
      default:      begin pick = head_i;       pop_cnt_o = 2'd1; end
    endcase
    if (!tick_i) pop_cnt_o = 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q     <= SILENCE_CODE;
      code_vld_q <= 1'b0;
    end else begin
      code_vld_q <= tick_i;
      if (tick_i) code_q <= pick;
    end
  end

  assign code_o     = code_q;
  assign code_vld_o = code_vld_q;

  AST_EMPTY_SILENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_i == '0) |=> (code_o == SILENCE_CODE)); // R4

endmodule

// File: rtl/vpjb_expand.sv
module vpjb_expand
  import vpjb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        code_vld_i,
  input  logic [7:0]  code_i,
  output logic [15:0] ch_a_o,
  output logic [15:0] ch_b_o,
  output logic        vld_o
);

  logic [15:0] dac_word;

  assign dac_word = lin_to_dac(alaw_to_lin(code_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_a_o <= DAC_MID;
      ch_b_o <= DAC_MID;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= code_vld_i;
      if (code_vld_i) begin
        ch_a_o <= dac_word;
        ch_b_o <= dac_word;
      end
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_vld_i |=> $stable(ch_a_o)); // R9

endmodule

// File: rtl/voice_playout_buffer.sv
module voice_playout_buffer
  import vpjb_pkg::*;
#(
  parameter int CAP = 255,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_byte_i,
  input  logic             tick_i,
  output logic [15:0]      ch_a_o,
  output logic [15:0]      ch_b_o,
  output logic             out_valid_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             overflow_o
);

  localparam int HALF = CAP / 2;

  logic [1:0]       pop_cnt;
  logic [7:0]       head_byte, next_byte, play_code;
  logic             push_ok, play_vld;
  logic [CNT_W-1:0] count;

  vpjb_ring #(.CAP(CAP)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (wr_en_i),
    .din_i     (wr_byte_i),
    .pop_cnt_i (pop_cnt),
    .head_o    (head_byte),
    .next_o    (next_byte),
    .count_o   (count),
    .push_ok_o (push_ok),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .ovf_o     (overflow_o)
  );

  vpjb_sel #(.CAP(CAP)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .count_i    (count),
    .head_i     (head_byte),
    .next_i     (next_byte),
    .pop_cnt_o  (pop_cnt),
    .code_o     (play_code),
    .code_vld_o (play_vld)
  );

  vpjb_expand u_expand (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_vld_i (play_vld),
    .code_i     (play_code),
    .ch_a_o     (ch_a_o),
    .ch_b_o     (ch_b_o),
    .vld_o      (out_valid_o)
  );

  assign fill_o = count;

  AST_NORMAL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && int'(fill_o) > 0 && int'(fill_o) <= HALF)
      |=> (int'(fill_o) == int'($past(fill_o)) - 1 + int'($past(push_ok)))); // R5
  AST_CATCHUP_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && int'(fill_o) > HALF)
      |=> (int'(fill_o) == int'($past(fill_o)) - 2 + int'($past(push_ok)))); // R6
  AST_SILENT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && empty_o)
      |=> (int'(fill_o) == int'($past(push_ok)))); // R7
  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ##1 out_valid_o); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(tick_i, 2)); // R9
  AST_CH_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (ch_a_o == ch_b_o)); // R8

endmodule

// File: tb/voice_playout_buffer_tb.sv
module voice_playout_buffer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CAP = 255;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_byte_i = 8'd0;
  logic        tick_i = 1'b0;
  logic [15:0] ch_a_o, ch_b_o;
  logic        out_valid_o;
  logic [7:0]  fill_o;
  logic        empty_o, full_o, overflow_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0]  mq[$];
  logic [15:0] eq[$];
  string       tq[$];
  int          vq[$];
  logic        ovf_m = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  voice_playout_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_byte_i(wr_byte_i),
    .tick_i(tick_i), .ch_a_o(ch_a_o), .ch_b_o(ch_b_o), .out_valid_o(out_valid_o),
    .fill_o(fill_o), .empty_o(empty_o), .full_o(full_o), .overflow_o(overflow_o)
  );

  // Reference decode, written from the segment/mantissa formula of R8
  function automatic logic [15:0] ref_dac(input logic [7:0] code);
    int a, s, m, mag, lin;
    a = int'(code) ^ 'h55;
    s = (a / 16) % 8;
    m = a % 16;
    if (s == 0) mag = m * 16 + 8;
    else        mag = (m * 16 + 264) * (1 << (s - 1));
    lin = (a >= 128) ? mag : -mag;
    ref_dac = 16'((lin + 32767) & 'hFFFF);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_status(input string req);
    int n;
    n = mq.size();
    check(int'(fill_o) == n, req, "fill", int'(fill_o), n);
    check(empty_o == (n == 0), req, "empty", int'(empty_o), int'(n == 0));
    check(full_o == (n == CAP), req, "full", int'(full_o), int'(n == CAP));
    check(overflow_o == ovf_m, req, "overflow", int'(overflow_o), int'(ovf_m));
  endtask

  // Driver: applies one cycle of stimulus and updates the reference model
  task automatic step(input logic wr, input logic [7:0] d, input logic tk);
    int n;
    logic [7:0] c;
    n = mq.size();
    wr_en_i = wr; wr_byte_i = d; tick_i = tk;
    if (tk) begin
      if (n == 0) begin
        c = 8'hD5; tq.push_back("R4");
      end else if (n > CAP / 2) begin
        c = mq.pop_front(); c = mq.pop_front(); tq.push_back("R6");
      end else begin
        c = mq.pop_front(); tq.push_back("R5");
      end
      eq.push_back(ref_dac(c));
      vq.push_back(cyc + 2);
    end
    if (wr) begin
      if (n < CAP) mq.push_back(d);
      else ovf_m = 1'b1;
    end
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  // Monitor: pops expected samples as pulses appear
  always @(negedge clk) begin
    if (rst_ni && out_valid_o) begin
      if (eq.size() == 0) begin
        check(1'b0, "R9", "unexpected out_valid", 1, 0);
      end else begin
        logic [15:0] e;
        string t;
        int vc;
        e = eq.pop_front(); t = tq.pop_front(); vc = vq.pop_front();
        check(ch_a_o == e, t, "ch_a sample", int'(ch_a_o), int'(e));
        check(ch_b_o == ch_a_o, "R8", "ch_b equals ch_a", int'(ch_b_o), int'(ch_a_o));
        check(cyc == vc, "R9", "valid cycle", cyc, vc);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check_status("R1");
    check(out_valid_o == 1'b0, "R1", "out_valid", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_status("R1");

    // R4 silence on empty ticks
    step(1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    check_status("R4");
    step(1'b0, 8'h00, 1'b0);

    // R8 codes over all segments and both signs, R5 normal playout
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 8'(i * 16 + i), 1'b0);
      check_status("R2");
    end
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 8'h00, 1'b1);
      step(1'b0, 8'h00, 1'b0);
      check_status("R5");
    end
    // R7 write plus tick in normal region
    step(1'b1, 8'hD5, 1'b1);
    check_status("R7");
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 1'b1);
    check_status("R5");
    // R7 write plus tick at empty: silence, fill becomes 1
    step(1'b1, 8'h80, 1'b1);
    check_status("R7");
    step(1'b0, 8'h00, 1'b1);
    check_status("R5");

    // Burst to exactly half then one above: R5 at 127, R6 at 128
    for (int i = 0; i < 127; i++) step(1'b1, 8'(i * 7 + 3), 1'b0);
    check_status("R2");
    step(1'b0, 8'h00, 1'b1);
    check_status("R5");
    step(1'b1, 8'h11, 1'b0);
    step(1'b1, 8'h22, 1'b0);
    check_status("R2");
    step(1'b0, 8'h00, 1'b1);
    check_status("R6");

    // Packet bursts until full, then overflow
    for (int i = 0; i < 3 * 84; i++) step(1'b1, 8'(i * 13 + 5), 1'b0);
    check_status("R3");
    check(overflow_o == 1'b1, "R3", "overflow after full", int'(overflow_o), 1);
    // R3 write plus tick at full: write dropped, two popped
    step(1'b1, 8'h99, 1'b1);
    check_status("R3");
    // Catch-up drain down to the half threshold
    for (int i = 0; i < 70; i++) step(1'b0, 8'h00, 1'b1);
    check_status("R6");
    // Drain rest, keep some write-plus-tick cycles
    for (int i = 0; i < 40; i++) step(1'b1, 8'(i + 200), 1'b1);
    check_status("R7");
    for (int i = 0; i < 140; i++) step(1'b0, 8'h00, 1'b1);
    check_status("R4");
    check(overflow_o == 1'b1, "R3", "overflow sticky", int'(overflow_o), 1);

    repeat (4) step(1'b0, 8'h00, 1'b0);
    check(eq.size() == 0, "R9", "pending samples", eq.size(), 0);
    finish_run();
  end

endmodule